// File: doc/BRIEF.md
# Byte-Parity Single-Port RAM with Byte Enables

A synchronous single-port memory whose words are made of bytes, each byte stored together with a ninth bit. When parity mode is selected, the write path generates even parity for every byte. On a read, logic outside the storage array recomputes parity and raises one error flag per byte when the stored ninth bit disagrees with its data. When control mode is selected, the ninth bit instead stores a bit supplied by the caller, and checking is switched off.

Writes are masked per byte. A byte that is not enabled keeps both its data and its ninth bit. Reads take one cycle, and the error flags come out in the same cycle as the data they describe. The array can be preloaded at elaboration from a packed parameter. Parity for the preloaded words is computed at the same time.

Top module: `byte_parity_ram`

## Requirements
- R1: When en_i is high at a clock edge, rdata_o and rbit_o show the word at addr_i as it was before that edge, starting right after that edge (one-cycle latency).
- R2: A write (en_i and we_i high) updates only the bytes whose be_i bit is set. Byte b is bits [8b+7:8b] and pairs with be_i[b], wbit_i[b], rbit_o[b] and err_o[b]. Bytes that are not enabled keep their data and their ninth bit.
- R3: In parity mode (par_mode_i = 1), the stored ninth bit of each written byte is the XOR of its eight data bits, which gives even parity over nine bits.
- R4: In control mode (par_mode_i = 0), the stored ninth bit of each written byte is wbit_i[b].
- R5: For a read issued in parity mode, err_o[b] is 1 exactly when the XOR of byte b and its stored ninth bit is 1. A single flipped ninth bit flags only its own byte.
- R6: For a read issued in control mode, err_o is all zero.
- R7: A read and a write to the same address in the same cycle return the data that was there before the write.
- R8: Word k of the array starts with bits [k*DATA_W +: DATA_W] of INIT_WORDS, with even parity as its ninth bits.
- R9: While rst_ni is low, rdata_o, rbit_o and err_o are zero. In a cycle with en_i low, nothing is written and all three outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the output registers |
| en_i | input | 1 | Access enable |
| we_i | input | 1 | Write when high (with en_i) |
| addr_i | input | AW | Word address |
| be_i | input | NB | Byte write enables |
| wdata_i | input | NB*8 | Write data |
| wbit_i | input | NB | Caller ninth bits, used in control mode |
| par_mode_i | input | 1 | 1: generate and check parity, 0: store raw control bits |
| rdata_o | output | NB*8 | Read data |
| rbit_o | output | NB | Stored ninth bits of the read word |
| err_o | output | NB | Per-byte parity error flags |

## Verification
The bench writes a ninth bit through control mode that breaks parity in a single byte, then reads the word back in parity mode. A checker that compared the wrong lanes or reduced the flags to one bit would raise the wrong flags. Partial byte-enable writes show whether a design also overwrites the ninth bits of masked bytes. A read and a write to the same address in one cycle expose a write-first array, which returns the new data. Reads in control mode of words with broken parity catch flags that are not gated by the mode. Cycles with the enable low catch outputs that do not hold.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic even_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/bpr_wr_encode.sv
module bpr_wr_encode
  import bpr_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic [NB*BYTE_W-1:0] wdata_i,
  input  logic [NB-1:0]        wbit_i,
  input  logic                 par_mode_i,
  output logic [NB-1:0]        wnin_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign wnin_o[b] = par_mode_i ? even_par(wdata_i[b*BYTE_W +: BYTE_W]) : wbit_i[b];
  end
endmodule

// File: rtl/bpr_store.sv
module bpr_store
  import bpr_pkg::*;
#(
  parameter int unsigned NB         = 4,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned AW         = $clog2(DEPTH),
  parameter logic [DEPTH*NB*BYTE_W-1:0] INIT_WORDS = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NB-1:0]        be_i,
  input  logic [NB*BYTE_W-1:0] wdata_i,
  input  logic [NB-1:0]        wnin_i,
  output logic [NB*BYTE_W-1:0] rdata_o,
  output logic [NB-1:0]        rnin_o
);
  localparam int unsigned DATA_W = NB * BYTE_W;
  localparam int unsigned LANE_W = BYTE_W + 1;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    initial begin
      for (int k = 0; k < DEPTH; k++) begin
        mem[k] = {even_par(INIT_WORDS[k*DATA_W + b*BYTE_W +: BYTE_W]),
                  INIT_WORDS[k*DATA_W + b*BYTE_W +: BYTE_W]};
      end
    end

    // write port, no reset on storage
    always_ff @(posedge clk_i) begin
      if (en_i && we_i && be_i[b]) begin
        mem[addr_i] <= {wnin_i[b], wdata_i[b*BYTE_W +: BYTE_W]};
      end
    end

    // read-before-write output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q <= '0;
      end else if (en_i) begin
        rd_q <= mem[addr_i];
      end
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = rd_q[BYTE_W-1:0];
    assign rnin_o[b]                   = rd_q[BYTE_W];
  end
endmodule

// File: rtl/bpr_check.sv
module bpr_check
  import bpr_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic [NB*BYTE_W-1:0] rdata_i,
  input  logic [NB-1:0]        rnin_i,
  input  logic                 chk_en_i,
  output logic [NB-1:0]        err_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign err_o[b] = chk_en_i && (even_par(rdata_i[b*BYTE_W +: BYTE_W]) != rnin_i[b]);
  end
endmodule

// File: rtl/byte_parity_ram.sv
module byte_parity_ram
  import bpr_pkg::*;
#(
  parameter int unsigned NB    = 4,
  parameter int unsigned DEPTH = 64,
  parameter logic [DEPTH*NB*BYTE_W-1:0] INIT_WORDS = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   addr_i,
  input  logic [NB-1:0]              be_i,
  input  logic [NB*BYTE_W-1:0]       wdata_i,
  input  logic [NB-1:0]              wbit_i,
  input  logic                       par_mode_i,
  output logic [NB*BYTE_W-1:0]       rdata_o,
  output logic [NB-1:0]              rbit_o,
  output logic [NB-1:0]              err_o
);
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned DATA_W = NB * BYTE_W;

  logic [NB-1:0]     wnin;
  logic [DATA_W-1:0] rdata;
  logic [NB-1:0]     rnin;
  logic              chk_q;

  bpr_wr_encode #(.NB(NB)) u_enc (
    .wdata_i    (wdata_i),
    .wbit_i     (wbit_i),
    .par_mode_i (par_mode_i),
    .wnin_o     (wnin)
  );

  bpr_store #(
    .NB         (NB),
    .DEPTH      (DEPTH),
    .AW         (AW),
    .INIT_WORDS (INIT_WORDS)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .wdata_i (wdata_i),
    .wnin_i  (wnin),
    .rdata_o (rdata),
    .rnin_o  (rnin)
  );

  // mode travels with the read so flags match the data they cover
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q <= 1'b0;
    end else if (en_i) begin
      chk_q <= par_mode_i;
    end
  end

  bpr_check #(.NB(NB)) u_chk (
    .rdata_i  (rdata),
    .rnin_i   (rnin),
    .chk_en_i (chk_q),
    .err_o    (err_o)
  );

  assign rdata_o = rdata;
  assign rbit_o  = rnin;
endmodule

// File: rtl/bpr_sva.sv
module bpr_sva #(
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [NB-1:0]    be_i,
  input logic [NB*8-1:0]  wdata_i,
  input logic [NB-1:0]    wbit_i,
  input logic             par_mode_i,
  input logic [NB*8-1:0]  rdata_o,
  input logic [NB-1:0]    rbit_o,
  input logic [NB-1:0]    err_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r9: assert (rdata_o == '0 && rbit_o == '0 && err_o == '0);
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> ($stable(rdata_o) && $stable(rbit_o) && $stable(err_o)));

  p_ctrl_no_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(par_mode_i)) |-> (err_o == '0));

  // full parity-mode write, then read of the same address next cycle
  p_par_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i, 2) && $past(we_i, 2) && $past(par_mode_i, 2) && ($past(be_i, 2) == '1) &&
     $past(en_i) && !$past(we_i) && $past(par_mode_i) && ($past(addr_i) == $past(addr_i, 2)))
    |-> (rdata_o == $past(wdata_i, 2) && err_o == '0));

  p_ctrl_readback_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i, 2) && $past(we_i, 2) && !$past(par_mode_i, 2) && ($past(be_i, 2) == '1) &&
     $past(en_i) && !$past(we_i) && ($past(addr_i) == $past(addr_i, 2)))
    |-> (rdata_o == $past(wdata_i, 2) && rbit_o == $past(wbit_i, 2)));
endmodule

bind byte_parity_ram bpr_sva #(.NB(NB), .AW(AW)) i_sva (.*);

// File: tb/test_byte_parity_ram.sv
module test_byte_parity_ram;
  localparam int CLK_PERIOD = 10;
  localparam int NB    = 4;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = NB * 8;

  function automatic logic [DEPTH*DW-1:0] gen_init();
    logic [DEPTH*DW-1:0] v;
    for (int k = 0; k < DEPTH; k++) v[k*DW +: DW] = 32'hA5C3_0F11 ^ (k * 32'h0103_0507);
    return v;
  endfunction
  localparam logic [DEPTH*DW-1:0] INIT = gen_init();

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, we = 0, pm = 1;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] be = '0, wb = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdata;
  logic [NB-1:0] rbit, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_parity_ram #(.NB(NB), .DEPTH(DEPTH), .INIT_WORDS(INIT)) i_byte_parity_ram (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wd), .wbit_i(wb), .par_mode_i(pm),
    .rdata_o(rdata), .rbit_o(rbit), .err_o(err));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] m_d [DEPTH];
  logic [NB-1:0] m_p [DEPTH];
  logic [DW-1:0] e_d = '0;
  logic [NB-1:0] e_p = '0, e_e = '0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk({tag, " rdata"}, rdata, e_d);
    chk({tag, " rbit"}, DW'(rbit), DW'(e_p));
    chk({tag, " err"}, DW'(err), DW'(e_e));
  endtask

  // one access: drive, update model, clock, compare at negedge
  task automatic cyc(string tag, logic e, logic w, logic [AW-1:0] a, logic [NB-1:0] bmask,
                     logic [DW-1:0] d, logic [NB-1:0] nb, logic mode);
    en = e; we = w; addr = a; be = bmask; wd = d; wb = nb; pm = mode;
    if (e) begin
      e_d = m_d[a];
      e_p = m_p[a];
      for (int b = 0; b < NB; b++) e_e[b] = mode && ((^m_d[a][b*8 +: 8]) ^ m_p[a][b]);
      if (w) begin
        for (int b = 0; b < NB; b++) begin
          if (bmask[b]) begin
            m_d[a][b*8 +: 8] = d[b*8 +: 8];
            m_p[a][b] = mode ? ^d[b*8 +: 8] : nb[b];
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      m_d[k] = INIT[k*DW +: DW];
      for (int b = 0; b < NB; b++) m_p[k][b] = ^m_d[k][b*8 +: 8];
    end
    repeat (3) @(negedge clk);
    cmp("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R8 preload readback
    for (int k = 0; k < DEPTH; k++) cyc("R8 R1 preload", 1, 0, AW'(k), '0, '0, '0, 1);

    // R2 R3 full then partial writes
    cyc("R3 write", 1, 1, 5, 4'hF, 32'h1234_5678, 4'h0, 1);
    cyc("R3 read", 1, 0, 5, '0, '0, '0, 1);
    cyc("R2 partial write", 1, 1, 5, 4'b0101, 32'hFFFF_FFFF, 4'hF, 1);
    cyc("R2 partial read", 1, 0, 5, '0, '0, '0, 1);

    // R4 control bits, R6 no error in control mode
    cyc("R4 ctrl write", 1, 1, 9, 4'hF, 32'h0101_0101, 4'b1010, 0);
    cyc("R4 R6 ctrl read", 1, 0, 9, '0, '0, '0, 0);
    // R5 single-byte corruption injected through control mode
    cyc("R5 inject", 1, 1, 12, 4'hF, 32'h0F0F_0F0F, 4'b0100, 0);
    cyc("R5 parity read", 1, 0, 12, '0, '0, '0, 1);
    if (err !== 4'b0100) begin
      fails++;
      $display("FAIL R5 single lane actual=%b expected=0100", err);
    end
    checks++;
    cyc("R6 ctrl read of bad word", 1, 0, 12, '0, '0, '0, 0);
    // R2 masked byte keeps broken ninth bit
    cyc("R2 mask keeps ninth", 1, 1, 12, 4'b1011, 32'h7777_7777, 4'h0, 1);
    cyc("R2 R5 reread", 1, 0, 12, '0, '0, '0, 1);

    // R7 same-address read and write
    cyc("R7 rw same addr", 1, 1, 20, 4'hF, 32'hDEAD_BEEF, '0, 1);
    cyc("R7 after", 1, 0, 20, '0, '0, '0, 1);

    // R9 enable low: no write, outputs hold
    cyc("R9 idle write ignored", 0, 1, 20, 4'hF, 32'h0, 4'hF, 0);
    cyc("R9 idle hold", 0, 0, 3, '0, '0, '0, 1);
    cyc("R9 no write seen", 1, 0, 20, '0, '0, '0, 1);

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc("R1 R2 R3 R4 R5 R6 random", 1'($urandom), 1'($urandom), AW'($urandom % 8),
          NB'($urandom), DW'($urandom), NB'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule